// File: doc/BRIEF.md
# GPIO Pin Register Bank

This block is a 32-bit general-purpose I/O controller behind a small word-wide register port. It holds three state words: the pin levels that the chip drives, a per-pin direction mask (a 1 marks a pin as an output), and a spare scratch word. The pin levels and the direction mask are driven out as vectors to the pad ring.

The level word cannot be written directly. It changes only through two write-only command offsets. The set command ORs the written mask into the levels. The clear command removes the written mask from the levels. Either command is accepted or refused as a whole. It is accepted when at least one written bit is also marked as an output in the direction word. An accepted command applies the full written mask, including bits that belong to input pins. A refused command changes nothing.

A refused command, or any access to an offset outside the map, raises an error flag for one cycle. The flag appears in the cycle after the access. The nine interrupt lines are present on the port list but are not functional, so they stay low at all times.

Top module: `gpio_regbank`

## Requirements
- R1: After reset, the level word, the direction word and the scratch word all read as zero, and `bus_err` is low.
- R2: A read, which is `bus_valid` high with `bus_write` low, returns data on `bus_rdata` in the same cycle. Offset 0x00 returns the levels, 0x04 the direction mask and 0x20 the scratch word. Offsets 0x08, 0x0C, 0x10, 0x14 and 0x18 return zero. When no read is active, `bus_rdata` is zero.
- R3: A write to 0x04 loads the whole write word into the direction mask. A write to 0x20 loads the whole write word into the scratch word.
- R4: A write to 0x08 sets levels to `levels | wdata` when `(direction & wdata)` is nonzero. The whole mask is applied, including bits of input pins.
- R5: A write to 0x0C sets levels to `levels & ~wdata` when `(direction & wdata)` is nonzero. The whole mask is applied.
- R6: A write to 0x08 or 0x0C with `(direction & wdata)` equal to zero leaves the levels unchanged. It raises `bus_err` for exactly the next cycle.
- R7: Writes to 0x00, 0x10, 0x14 and 0x18 change no state and raise no error.
- R8: An access, read or write, to any other offset changes no state and raises `bus_err` for exactly the next cycle. Offsets that are not multiples of four count as other offsets.
- R9: `irq_low` and `irq_high` are zero at all times.
- R10: A write takes effect on the rising clock edge at which `bus_valid` is high. `pin_level` and `pin_dir` show the new values right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe, one word per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_offset | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| bus_err | output | 1 | One-cycle error pulse for a refused command or an unmapped access |
| pin_level | output | 32 | Current pin levels |
| pin_dir | output | 32 | Direction mask, 1 = output |
| irq_low | output | 8 | Per-pin interrupt lines, held low |
| irq_high | output | 1 | Combined interrupt line, held low |

## Verification
A wrong level or direction bit is visible on `pin_level` or `pin_dir` right after the edge that corrupts it. It stays visible until a later command happens to overwrite that bit. A fault in the scratch word can only be seen through a read of 0x20, so the scratch word is read back regularly. A wrong accept/refuse decision shows in two places one cycle after the command: as a level change that should not have happened or is missing, and as a wrong `bus_err` value. A decode fault shows in the same cycle as a wrong `bus_rdata`, or on the next edge as misplaced state.

// File: rtl/gpio_regbank_pkg.sv
package gpio_regbank_pkg;

  localparam int unsigned OFS_LEVEL = 32'h00;
  localparam int unsigned OFS_DIR   = 32'h04;
  localparam int unsigned OFS_SET   = 32'h08;
  localparam int unsigned OFS_CLR   = 32'h0C;
  localparam int unsigned OFS_RISE  = 32'h10;
  localparam int unsigned OFS_FALL  = 32'h14;
  localparam int unsigned OFS_EDGE  = 32'h18;
  localparam int unsigned OFS_AUX   = 32'h20;

  typedef struct packed {
    logic lvl;
    logic dir;
    logic set;
    logic clr;
    logic aux;
    logic unmapped;
  } gpio_hit_t;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_regbank_pkg::*;
#(
  parameter int OFS_W = 6
) (
  input  logic [OFS_W-1:0] ofs,
  output gpio_hit_t        hit
);

  always_comb begin
    int unsigned o;
    o = 32'(ofs);
    hit = '0;
    case (o)
      OFS_LEVEL: hit.lvl = 1'b1;
      OFS_DIR:   hit.dir = 1'b1;
      OFS_SET:   hit.set = 1'b1;
      OFS_CLR:   hit.clr = 1'b1;
      OFS_AUX:   hit.aux = 1'b1;
      OFS_RISE, OFS_FALL, OFS_EDGE: hit = '0;
      default:   hit.unmapped = 1'b1;
    endcase
  end

endmodule

// File: rtl/gpio_word_reg.sv
module gpio_word_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

endmodule

// File: rtl/gpio_level_reg.sv
module gpio_level_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_req,
  input  logic              clr_req,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] dir,
  output logic [DATA_W-1:0] level,
  output logic              set_fire,
  output logic              clr_fire,
  output logic              reject
);

  function automatic logic touches_output(input logic [DATA_W-1:0] mask,
                                          input logic [DATA_W-1:0] data);
    return |(mask & data);
  endfunction

  function automatic logic [DATA_W-1:0] next_level(
      input logic [DATA_W-1:0] cur, input logic [DATA_W-1:0] data,
      input logic do_set, input logic do_clr);
    logic [DATA_W-1:0] r;
    r = cur;
    if (do_set) r = r | data;
    if (do_clr) r = r & ~data;
    return r;
  endfunction

  logic ok;
  assign ok       = touches_output(dir, wdata);
  assign set_fire = set_req & ok;
  assign clr_fire = clr_req & ok;
  assign reject   = (set_req | clr_req) & ~ok;

  always_ff @(posedge clk) begin
    if (!rst_n) level <= '0;
    else if (set_fire | clr_fire)
      level <= next_level(level, wdata, set_fire, clr_fire);
  end

endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
  import gpio_regbank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              rd_en,
  input  gpio_hit_t         hit,
  input  logic [DATA_W-1:0] level,
  input  logic [DATA_W-1:0] dir,
  input  logic [DATA_W-1:0] aux,
  output logic [DATA_W-1:0] rdata
);

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (hit.lvl) rdata = level;
      if (hit.dir) rdata = dir;
      if (hit.aux) rdata = aux;
    end
  end

endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import gpio_regbank_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int OFS_W     = 6,
  parameter int N_IRQ_LOW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [OFS_W-1:0]     bus_offset,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 bus_err,
  output logic [DATA_W-1:0]    pin_level,
  output logic [DATA_W-1:0]    pin_dir,
  output logic [N_IRQ_LOW-1:0] irq_low,
  output logic                 irq_high
);

  gpio_hit_t   hit;
  logic        wr_en, rd_en;
  logic        set_fire, clr_fire, reject, acc_unmapped;
  logic [DATA_W-1:0] aux_q;

  assign wr_en = bus_valid & bus_write;
  assign rd_en = bus_valid & ~bus_write;

  gpio_addr_decode #(.OFS_W(OFS_W)) u_dec (
    .ofs (bus_offset),
    .hit (hit)
  );

  assign acc_unmapped = bus_valid & hit.unmapped;

  gpio_word_reg #(.DATA_W(DATA_W)) u_dir (
    .clk (clk), .rst_n (rst_n), .load (wr_en & hit.dir),
    .d (bus_wdata), .q (pin_dir)
  );

  gpio_word_reg #(.DATA_W(DATA_W)) u_aux (
    .clk (clk), .rst_n (rst_n), .load (wr_en & hit.aux),
    .d (bus_wdata), .q (aux_q)
  );

  gpio_level_reg #(.DATA_W(DATA_W)) u_lvl (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_req  (wr_en & hit.set),
    .clr_req  (wr_en & hit.clr),
    .wdata    (bus_wdata),
    .dir      (pin_dir),
    .level    (pin_level),
    .set_fire (set_fire),
    .clr_fire (clr_fire),
    .reject   (reject)
  );

  gpio_rd_mux #(.DATA_W(DATA_W)) u_rd (
    .rd_en (rd_en), .hit (hit), .level (pin_level),
    .dir (pin_dir), .aux (aux_q), .rdata (bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) bus_err <= 1'b0;
    else        bus_err <= acc_unmapped | reject;
  end

  assign irq_low  = '0;
  assign irq_high = 1'b0;

endmodule

// File: rtl/gpio_regbank_chk.sv
module gpio_regbank_chk #(
  parameter int DATA_W    = 32,
  parameter int OFS_W     = 6,
  parameter int N_IRQ_LOW = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_valid,
  input logic                 bus_write,
  input logic [OFS_W-1:0]     bus_offset,
  input logic [DATA_W-1:0]    bus_wdata,
  input logic                 bus_err,
  input logic [DATA_W-1:0]    pin_level,
  input logic [DATA_W-1:0]    pin_dir,
  input logic [N_IRQ_LOW-1:0] irq_low,
  input logic                 irq_high,
  input logic                 set_fire,
  input logic                 clr_fire,
  input logic                 reject,
  input logic                 acc_unmapped
);

  logic wr;
  logic [7:0] o8;
  assign wr = bus_valid & bus_write;
  assign o8 = 8'(bus_offset);

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_low == '0) && !irq_high);

  // R4
  set_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_fire |=> pin_level == ($past(pin_level) | $past(bus_wdata)));

  // R5
  clr_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fire |=> pin_level == ($past(pin_level) & ~$past(bus_wdata)));

  // R6
  refuse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> $stable(pin_level) && bus_err);

  // R8
  unmapped_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_unmapped |=> bus_err && $stable(pin_level) && $stable(pin_dir));

  // R3
  dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && o8 == 8'h04) |=> pin_dir == $past(bus_wdata));

  // R7
  inert_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (o8 == 8'h00 || o8 == 8'h10 || o8 == 8'h14 || o8 == 8'h18))
      |=> $stable(pin_level) && $stable(pin_dir) && !bus_err);

  // R6
  fire_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({set_fire, clr_fire, reject}) <= 1);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> $stable(pin_level) && $stable(pin_dir) && !bus_err);

endmodule

bind gpio_regbank gpio_regbank_chk #(
  .DATA_W(DATA_W), .OFS_W(OFS_W), .N_IRQ_LOW(N_IRQ_LOW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_valid    (bus_valid),
  .bus_write    (bus_write),
  .bus_offset   (bus_offset),
  .bus_wdata    (bus_wdata),
  .bus_err      (bus_err),
  .pin_level    (pin_level),
  .pin_dir      (pin_dir),
  .irq_low      (irq_low),
  .irq_high     (irq_high),
  .set_fire     (set_fire),
  .clr_fire     (clr_fire),
  .reject       (reject),
  .acc_unmapped (acc_unmapped)
);

// File: tb/tb_gpio_regbank.sv
`timescale 1ns/1ps
module tb_gpio_regbank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [5:0]  bus_offset = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, pin_level, pin_dir;
  logic        bus_err, irq_high;
  logic [7:0]  irq_low;

  int compared = 0, mismatched = 0;
  bit done = 0;

  // reference state
  int unsigned m_lvl = 0, m_dir = 0, m_aux = 0;
  bit m_err = 0;

  always #10 clk = ~clk;

  gpio_regbank dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_offset(bus_offset), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .pin_level(pin_level), .pin_dir(pin_dir),
    .irq_low(irq_low), .irq_high(irq_high)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int unsigned exp_read();
    if (!bus_valid || bus_write) return 0;
    case (int'(bus_offset))
      0:  return m_lvl;
      4:  return m_dir;
      32: return m_aux;
      default: return 0;
    endcase
  endfunction

  task automatic model_edge();
    int unsigned d;
    d = bus_wdata;
    if (!rst_n) begin
      m_lvl = 0; m_dir = 0; m_aux = 0; m_err = 0;
      return;
    end
    m_err = 0;
    if (!bus_valid) return;
    case (int'(bus_offset))
      0, 16, 20, 24: ;
      4:  if (bus_write) m_dir = d;
      32: if (bus_write) m_aux = d;
      8:  if (bus_write) begin
            if ((m_dir & d) != 0) m_lvl = m_lvl | d; else m_err = 1;
          end
      12: if (bus_write) begin
            if ((m_dir & d) != 0) m_lvl = m_lvl & ~d; else m_err = 1;
          end
      default: m_err = 1;
    endcase
  endtask

  task automatic compare_all();
    chk("R2 rdata", bus_rdata, exp_read());
    chk("R4/R5/R10 pin_level", pin_level, m_lvl);
    chk("R3/R10 pin_dir", pin_dir, m_dir);
    chk("R6/R8 bus_err", {31'b0, bus_err}, {31'b0, m_err});
    chk("R9 irq", {23'b0, irq_high, irq_low}, 32'h0);
  endtask

  task automatic access(bit v, bit w, int off, int unsigned d);
    bus_valid = v; bus_write = w; bus_offset = 6'(off); bus_wdata = d;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    access(0, 0, 0, 0);
  endtask

  initial begin
    #200000000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) idle();
    rst_n = 1'b1;
    idle();
    // R1 reset state
    chk("R1 level after reset", pin_level, 0);
    chk("R1 dir after reset", pin_dir, 0);
    chk("R1 err after reset", {31'b0, bus_err}, 0);
    access(1, 0, 32'h20, 0);
    chk("R1 aux after reset", bus_rdata, 0);

    // R3 direction and scratch loads, R10 visible after the edge
    access(1, 1, 32'h04, 32'h0000_00F0);
    chk("R10 dir after edge", pin_dir, 32'h0000_00F0);
    access(1, 1, 32'h20, 32'hA5A5_1234);
    access(1, 0, 32'h20, 0);
    chk("R3 aux readback", bus_rdata, 32'hA5A5_1234);

    // R4 whole mask applied when one bit overlaps
    access(1, 1, 32'h08, 32'h0000_0F10);
    chk("R4 set full mask", pin_level, 32'h0000_0F10);
    // R6 refused set
    access(1, 1, 32'h08, 32'h0000_000F);
    chk("R6 level held", pin_level, 32'h0000_0F10);
    chk("R6 err pulse", {31'b0, bus_err}, 1);
    idle();
    chk("R6 err one cycle", {31'b0, bus_err}, 0);
    // R5 clear
    access(1, 1, 32'h0C, 32'h0000_0110);
    chk("R5 clear", pin_level, 32'h0000_0E00);
    // R6 refused clear
    access(1, 1, 32'h0C, 32'h0000_0E00);
    chk("R6 clear held", pin_level, 32'h0000_0E00);
    // R7 inert writes
    access(1, 1, 32'h00, 32'hFFFF_FFFF);
    chk("R7 level write ignored", pin_level, 32'h0000_0E00);
    chk("R7 no err", {31'b0, bus_err}, 0);
    access(1, 1, 32'h14, 32'hFFFF_FFFF);
    chk("R7 edge cfg ignored", pin_dir, 32'h0000_00F0);
    // R2 reads of command offsets are zero
    access(1, 0, 32'h08, 0);
    chk("R2 set reads zero", bus_rdata, 0);
    access(1, 0, 32'h00, 0);
    chk("R2 level read", bus_rdata, 32'h0000_0E00);
    // R8 unmapped and unaligned
    access(1, 1, 32'h24, 32'hFFFF_FFFF);
    chk("R8 unmapped write err", {31'b0, bus_err}, 1);
    chk("R8 dir untouched", pin_dir, 32'h0000_00F0);
    access(1, 0, 32'h05, 0);
    chk("R8 unaligned read err", {31'b0, bus_err}, 1);
    chk("R8 unaligned read zero", bus_rdata, 0);

    // mixed traffic against the reference model
    for (int i = 0; i < 2000; i++) begin
      int unsigned r, off, d;
      r = $urandom;
      case (r % 12)
        0, 1: off = 8; 2, 3: off = 12; 4: off = 4; 5: off = 32; 6: off = 0;
        7: off = 16 + 4 * ((r >> 4) % 3);
        8: off = (r >> 8) % 64;
        default: off = 4 * ((r >> 8) % 9);
      endcase
      d = $urandom;
      if ((r >> 20) % 3 == 0) d = d & 32'h0000_FFFF;
      if ((r >> 22) % 5 == 0) d = 32'h1 << ((r >> 24) % 32);
      access((r >> 16) % 8 != 0, (r >> 19) % 2 == 1, int'(off), d);
      if (i == 1000) begin
        rst_n = 1'b0; idle(); rst_n = 1'b1;
        chk("R1 mid-run reset", pin_level | pin_dir, 0);
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule